// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing protocol engine of a 256-byte serial memory. It watches the SCL and SDA lines of a two-wire bus and passes both lines through synchronizers into a system clock. That clock runs at least sixteen times faster than SCL. The engine decodes start and stop conditions and receives a device address byte and then an 8-bit word address. It acknowledges by pulling SDA low through an open-drain output enable. It serves single-byte writes, page writes, reads from the current address, random reads and sequential reads.

The engine holds the word address counter. On writes the counter steps only inside an aligned page. On reads it steps across the whole array. Each received data byte goes out as a one-cycle strobe to a separate commit engine. A stop condition then tells that engine to start its internal write cycle. The commit engine reports that cycle on `busy_i`. While `busy_i` is high the engine refuses its own device address, so a master can poll for completion. Read data comes from a register array through a combinational address/data pair.

Top module: `ser_mem_slave`

## Requirements
- R1: After reset the SDA output enable is low, and the write strobe and commit pulse are low.
- R2: The byte after a start is accepted only when bits 7:4 equal 1010 and bits 3:1 equal `strap_i`. Bit 0 selects a read when it is 1 and a write when it is 0. On a mismatch the engine gives no acknowledge and stays idle until the next start.
- R3: The engine acknowledges every accepted byte by raising `sda_oe_o` for the ninth SCL clock. Incoming bits are taken on rising SCL edges. The engine changes SDA only after a falling SCL edge, or to release SDA on a start or stop.
- R4: Each received data byte of a write produces one `wr_valid_o` cycle carrying `wr_addr_o` and `wr_data_o`. A stop that follows at least one data byte produces one `wr_commit_o` cycle.
- R5: After each written byte the low PAGE_BITS (default 3) address bits increment and wrap inside the page. The upper address bits do not change.
- R6: A read with no word address returns the byte at the counter, which is the last accessed address plus one. The byte is taken from `rd_data_i` at `rd_addr_o` and shifted out MSB first.
- R7: A write carrying only a word address, followed by a repeated start and a read device address, returns the byte at that word address.
- R8: A sequential read continues while the master acknowledges each byte. The read counter rolls over from 255 to 0.
- R9: If `busy_i` is high when the device address completes, the engine does not acknowledge it.
- R10: A start seen anywhere, including in the middle of a byte, aborts the transfer, releases SDA and restarts device address reception.
- R11: When the master leaves SDA high in a read acknowledge slot, the engine releases SDA and goes idle. The next current-address read continues from the following address.
- R12: The engine drives SDA only in its acknowledge slots and in the bit slots of read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16x SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sda_oe_o | output | 1 | Pulls SDA low when high (open drain) |
| strap_i | input | 3 | Hard-wired device select bits |
| busy_i | input | 1 | Commit engine write cycle in progress |
| rd_addr_o | output | 8 | Read address to the register array |
| rd_data_i | input | 8 | Read data from the register array |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | 8 | Address of the strobed byte |
| wr_data_o | output | 8 | Value of the strobed byte |
| wr_commit_o | output | 1 | One-cycle pulse at stop: start the write cycle |

## Verification
The assertions check several rules on every cycle. SDA moves only after an SCL fall or a bus condition, and a start always releases SDA. A commit pulse only ever follows a stop, and write strobes occur only in the data phase of a write. No acknowledge is given while busy. On the address counter, page writes never alter the upper address bits and reads wrap from 255 to 0. The bench scenarios cover the rest: the actual byte values read back after commits, the rejection of wrong prefixes and strap values, the current-address continuity after a master's not-acknowledge, and the recovery after a start cuts into a byte. A per-clock monitor reports any SDA drive outside the slots the bench's model permits.

// File: rtl/ser_mem_pkg.sv
package ser_mem_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_RDAT,
    ST_MACK
  } eng_st_e;
endpackage

// File: rtl/ser_sync_ff.sv
module ser_sync_ff #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ser_bus_events.sv
module ser_bus_events #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw_in, syn_out;
  logic scl_q, sda_q;

  assign raw_in = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    ser_sync_ff #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_in[g]),
      .q_o   (syn_out[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= syn_out[1];
      sda_q <= syn_out[0];
    end
  end

  assign sda_o      = syn_out[0];
  assign scl_rise_o = syn_out[1] & ~scl_q;
  assign scl_fall_o = ~syn_out[1] & scl_q;
  // SDA edge while SCL held high on both samples
  assign start_o    = syn_out[1] & scl_q & sda_q & ~syn_out[0];
  assign stop_o     = syn_out[1] & scl_q & ~sda_q & syn_out[0];
endmodule

// File: rtl/ser_addr_ctr.sv
module ser_addr_ctr #(
  parameter int unsigned AW = 8,
  parameter int unsigned PW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_rd_i,
  input  logic          inc_wr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] ctr_q, rd_nxt, wr_nxt;

  assign rd_nxt = ctr_q + 1'b1;

  if (PW == 0) begin : g_no_page
    assign wr_nxt = ctr_q;
  end else if (PW >= AW) begin : g_full_page
    assign wr_nxt = rd_nxt;
  end else begin : g_page
    logic [PW-1:0] low_nxt;
    assign low_nxt = ctr_q[PW-1:0] + 1'b1;
    assign wr_nxt  = {ctr_q[AW-1:PW], low_nxt};

    p_page_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inc_wr_i |=> addr_o[AW-1:PW] == $past(addr_o[AW-1:PW]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctr_q <= '0;
    else if (load_i)   ctr_q <= load_val_i;
    else if (inc_rd_i) ctr_q <= rd_nxt;
    else if (inc_wr_i) ctr_q <= wr_nxt;
  end

  assign addr_o = ctr_q;

  p_rd_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_rd_i && !load_i && addr_o == {AW{1'b1}}) |=> addr_o == '0);
endmodule

// File: rtl/ser_mem_slave.sv
module ser_mem_slave
  import ser_mem_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PAGE_BITS   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       busy_i,
  output logic [7:0] rd_addr_o,
  input  logic [7:0] rd_data_i,
  output logic       wr_valid_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       wr_commit_o
);
  localparam int unsigned AW    = BYTE_W;
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  ser_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  eng_st_e          state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       rx_q, tx_q;
  logic             ack_act_q, rd_mode_q, macked_q, wr_any_q, oe_q;
  logic             ld_q, inc_rd_q, inc_wr_q;
  logic [7:0]       ld_val_q, ctr;
  logic             dev_match;

  ser_addr_ctr #(.AW(AW), .PW(PAGE_BITS)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ld_q),
    .load_val_i(ld_val_q),
    .inc_rd_i  (inc_rd_q),
    .inc_wr_i  (inc_wr_q),
    .addr_o    (ctr)
  );

  assign dev_match = (rx_q[7:4] == DEV_PREFIX) && (rx_q[3:1] == strap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      ack_act_q   <= 1'b0;
      rd_mode_q   <= 1'b0;
      macked_q    <= 1'b0;
      wr_any_q    <= 1'b0;
      oe_q        <= 1'b0;
      ld_q        <= 1'b0;
      ld_val_q    <= '0;
      inc_rd_q    <= 1'b0;
      inc_wr_q    <= 1'b0;
      wr_valid_o  <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
    end else begin
      ld_q        <= 1'b0;
      inc_rd_q    <= 1'b0;
      inc_wr_q    <= 1'b0;
      wr_valid_o  <= 1'b0;
      wr_commit_o <= 1'b0;
      if (start_det) begin
        state_q   <= ST_DEV;
        cnt_q     <= '0;
        ack_act_q <= 1'b0;
        oe_q      <= 1'b0;
      end else if (stop_det) begin
        state_q     <= ST_IDLE;
        ack_act_q   <= 1'b0;
        oe_q        <= 1'b0;
        wr_commit_o <= wr_any_q;
        wr_any_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_DEV, ST_WADR, ST_WDAT: begin
            if (scl_rise && !ack_act_q && cnt_q != LAST_BIT) begin
              rx_q  <= {rx_q[6:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && ack_act_q) begin
              // end of ninth clock: release, move on
              oe_q      <= 1'b0;
              ack_act_q <= 1'b0;
              cnt_q     <= '0;
              if (state_q == ST_DEV) begin
                if (rd_mode_q) begin
                  state_q  <= ST_RDAT;
                  tx_q     <= rd_data_i;
                  oe_q     <= ~rd_data_i[7];
                  inc_rd_q <= 1'b1;
                end else begin
                  state_q <= ST_WADR;
                end
              end else begin
                state_q <= ST_WDAT;
              end
            end else if (scl_fall && cnt_q == LAST_BIT) begin
              if (state_q == ST_DEV) begin
                if (dev_match && !busy_i) begin
                  oe_q      <= 1'b1;
                  ack_act_q <= 1'b1;
                  rd_mode_q <= rx_q[0];
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_WADR) begin
                oe_q      <= 1'b1;
                ack_act_q <= 1'b1;
                ld_q      <= 1'b1;
                ld_val_q  <= rx_q;
              end else begin
                oe_q       <= 1'b1;
                ack_act_q  <= 1'b1;
                wr_valid_o <= 1'b1;
                wr_addr_o  <= ctr;
                wr_data_o  <= rx_q;
                inc_wr_q   <= 1'b1;
                wr_any_q   <= 1'b1;
              end
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == LAST_BIT) begin
                oe_q    <= 1'b0;
                state_q <= ST_MACK;
              end else if (cnt_q != '0) begin
                tx_q <= {tx_q[6:0], 1'b0};
                oe_q <= ~tx_q[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              macked_q <= ~sda_s;
            end else if (scl_fall) begin
              if (macked_q) begin
                state_q  <= ST_RDAT;
                cnt_q    <= '0;
                tx_q     <= rd_data_i;
                oe_q     <= ~rd_data_i[7];
                inc_rd_q <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign rd_addr_o = ctr;

  p_oe_after_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  p_commit_at_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |-> $past(stop_det));

  p_strobe_in_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> state_q == ST_WDAT);

  p_no_ack_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_o) && state_q == ST_DEV) |-> !$past(busy_i));

  p_start_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);
endmodule

// File: tb/ser_mem_slave_bench.sv
module ser_mem_slave_bench;
  localparam int Q      = 20;
  localparam int BUSY_N = 2000;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, busy = 1'b0;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  logic wr_valid, wr_commit;
  wire  sda_line = sda_m & ~sda_oe;

  int total = 0, bad = 0;
  logic drv_ok = 1'b0;
  int drv_viol = 0;

  logic [7:0] mem_act [256];
  logic [7:0] exp_mem [256];
  int exp_ptr = 0;
  logic [7:0] pend_a[$], pend_d[$], exp_wa[$], exp_wd[$];
  int busy_cnt = 0;

  always #2.5 clk = ~clk;

  assign rd_data = mem_act[rd_addr];

  ser_mem_slave u_ser_mem_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(STRAP), .busy_i(busy),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_commit_o(wr_commit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural commit engine and per-clock drive monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe && !drv_ok) drv_viol++;
      if (wr_valid) begin
        if (exp_wa.size() == 0) chk(0, "R4 unexpected strobe", wr_addr, 0);
        else begin
          chk(wr_addr == exp_wa[0], "R5 strobe address", wr_addr, exp_wa[0]);
          chk(wr_data == exp_wd[0], "R4 strobe data", wr_data, exp_wd[0]);
          void'(exp_wa.pop_front());
          void'(exp_wd.pop_front());
        end
        pend_a.push_back(wr_addr);
        pend_d.push_back(wr_data);
      end
      if (wr_commit) begin
        while (pend_a.size() > 0) begin
          mem_act[pend_a[0]] = pend_d[0];
          void'(pend_a.pop_front());
          void'(pend_d.pop_front());
        end
        busy = 1'b1;
        busy_cnt = BUSY_N;
      end else if (busy_cnt > 0) begin
        busy_cnt--;
        if (busy_cnt == 0) busy = 1'b0;
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_start();
    drv_ok = 1'b0;
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(8);
  endtask

  task automatic t_stop();
    drv_ok = 1'b0;
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic t_bit(input logic b, input logic allow, output logic s);
    drv_ok = allow;
    sda_m = b; wt(Q);
    scl_m = 1'b1; wt(Q/2);
    s = sda_line; wt(Q/2);
    scl_m = 1'b0;
    drv_ok = 1'b1; wt(8);
  endtask

  task automatic tx_byte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) t_bit(d[i], 1'b0, s);
    t_bit(1'b1, 1'b1, s);
    acked = ~s;
  endtask

  task automatic rx_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      t_bit(1'b1, 1'b1, s);
      d[i] = s;
    end
    t_bit(~mack, 1'b0, s);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] st, input logic rw);
    return {4'b1010, st, rw};
  endfunction

  task automatic poll_done();
    logic a;
    int n = 0;
    t_start(); tx_byte(dev(STRAP, 1'b0), a); t_stop();
    chk(!a, "R9 no ack while busy", a, 0);
    do begin
      wt(300);
      t_start(); tx_byte(dev(STRAP, 1'b0), a); t_stop();
      n++;
    end while (!a && n < 20);
    chk(a, "R9 ack after write cycle", a, 1);
  endtask

  task automatic do_write(input logic [7:0] adr, input logic [7:0] d[], input string req);
    logic a;
    logic [7:0] p = adr;
    t_start();
    tx_byte(dev(STRAP, 1'b0), a); chk(a, "R3 ack device", a, 1);
    tx_byte(adr, a);              chk(a, "R3 ack word address", a, 1);
    foreach (d[i]) begin
      exp_wa.push_back(p); exp_wd.push_back(d[i]);
      exp_mem[p] = d[i];
      tx_byte(d[i], a); chk(a, {req, " ack data"}, a, 1);
      p = {p[7:3], p[2:0] + 3'd1};
    end
    t_stop();
    exp_ptr = p;
    poll_done();
  endtask

  task automatic read_seq(input int n, input string req);
    logic a;
    logic [7:0] d;
    t_start();
    tx_byte(dev(STRAP, 1'b1), a); chk(a, "R2 ack read device", a, 1);
    for (int i = 0; i < n; i++) begin
      rx_byte(i != n - 1, d);
      chk(d == exp_mem[exp_ptr], req, d, exp_mem[exp_ptr]);
      exp_ptr = (exp_ptr + 1) % 256;
    end
    t_stop();
  endtask

  task automatic set_ptr(input logic [7:0] adr);
    logic a;
    t_start();
    tx_byte(dev(STRAP, 1'b0), a); chk(a, "R7 ack dummy write", a, 1);
    tx_byte(adr, a);              chk(a, "R7 ack address", a, 1);
    exp_ptr = adr;
  endtask

  initial begin
    logic a, s;
    for (int i = 0; i < 256; i++) begin
      mem_act[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    wt(10);
    chk(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    wt(10);
    chk(sda_oe == 1'b0 && wr_valid == 1'b0 && wr_commit == 1'b0, "R1 idle outputs",
        {sda_oe, wr_valid, wr_commit}, 0);

    // R2: wrong strap and wrong prefix are refused
    t_start(); tx_byte(dev(3'b100, 1'b0), a); t_stop();
    chk(!a, "R2 strap mismatch", a, 0);
    t_start(); tx_byte(8'b1011_1010, a); t_stop();
    chk(!a, "R2 prefix mismatch", a, 0);

    do_write(8'h10, '{8'hA7}, "R4");
    do_write(8'h3E, '{8'h11, 8'h22, 8'h33, 8'h44}, "R5");
    chk(exp_ptr == 8'h3A, "R5 model pointer", exp_ptr, 8'h3A);

    read_seq(1, "R6 current read");
    set_ptr(8'h10); read_seq(1, "R7 random read");
    set_ptr(8'h38); read_seq(2, "R7 random page data");
    set_ptr(8'hFE); read_seq(4, "R8 sequential wrap");
    read_seq(1, "R11 continue after nack");

    // R10: start cuts a device address short
    t_start();
    for (int i = 0; i < 4; i++) t_bit(i[0], 1'b0, s);
    set_ptr(8'h3F); read_seq(1, "R10 transfer after abort");

    chk(exp_wa.size() == 0, "R4 all strobes seen", exp_wa.size(), 0);
    chk(drv_viol == 0, "R12 drive outside slots", drv_viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule